// File: doc/BRIEF.md
# Serial SAR Converter Read Sequencer

This block runs the host side of a three-wire link to a low-power successive-approximation converter that has no clock of its own. A frame opens when chip select goes low. The converter powers up and tracks its input for a programmed number of system cycles. Raising chip select freezes the sample and starts the conversion. The controller then supplies a burst of sixteen serial clocks, which both drive the conversion and shift out the result. It reads the data line, discards the four zero bits at the head of each frame, and presents a 12-bit result with a one-cycle strobe.

A frame starts on a single-cycle start request, or on a tick from a built-in rate timer whose period is a run-time value. All timing values are counted in system clock cycles: acquisition length, serial-clock half period and sample period. Between frames both link lines rest high. A trigger that arrives while a frame is running does not start a new one; it increments a drop counter instead.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, chip select and serial clock are high, the valid strobe is low, the drop counter is zero and the result is zero.
- R2: A trigger sampled in the idle state drives chip select low for exactly `cfg_acq_cyc` system cycles; a value of 0 acts as 1. The serial clock stays high throughout.
- R3: After chip select rises, the serial clock stays high for H cycles and then alternates low and high phases of H cycles each. H is `cfg_half_cyc`, with 0 acting as 1.
- R4: Each frame has exactly 16 serial-clock falling edges, all while chip select is high.
- R5: The data line is sampled in the last system cycle before each falling edge. The 16 samples form a frame word, first sample in bit 15. `res_data_o` takes bits 11..0 of that word. `res_valid_o` pulses for one cycle on the same clock edge that drives the sixteenth rising edge.
- R6: `res_pad_err_o` is updated together with each result. It is 1 exactly when any of frame bits 15..12 (the first four samples) is 1.
- R7: A trigger (start request or rate tick) that arrives while a frame is in progress starts nothing and adds one to `drop_cnt_o`.
- R8: With `cfg_period_cyc` = T nonzero and T longer than a frame, frames begin every T cycles. With T = 0, the timer starts no frame.
- R9: Once a frame ends, chip select and the serial clock both stay high until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle conversion request |
| cfg_acq_cyc | input | ACQ_W | Chip-select low (power-up and acquire) length in cycles |
| cfg_half_cyc | input | HALF_W | Serial clock half period in cycles |
| cfg_period_cyc | input | PER_W | Rate timer period in cycles, 0 disables |
| adc_sdata_i | input | 1 | Serial data from the converter |
| adc_cs_n_o | output | 1 | Active-low chip select |
| adc_sclk_o | output | 1 | Serial / conversion clock |
| res_data_o | output | DATA_BITS | Last conversion result |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_pad_err_o | output | 1 | Nonzero bit seen in the leading pad |
| busy_o | output | 1 | Frame in progress |
| drop_cnt_o | output | DROP_W | Count of discarded triggers |

## Verification
If the edge counter is off by one, the 16-edge count at the link is wrong in that same frame, and every later result is shifted by one bit. If the capture point is in the wrong phase, the result fails the comparison with the word the bench loaded into its converter model. The pad flag then rises even though the model sent zeros. A stuck frame state shows up within one frame period: the drop counter climbs and no strobe follows. A broken rate timer shows up as wrong spacing between chip-select falling edges within a few periods.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_seq_rate.sv
// Free-running rate timer: one registered tick every `period` cycles.
module adc_seq_rate #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (period == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= period - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_sclk.sv
// Serial clock burst generator: idles high, FRAME_BITS periods while run.
module adc_seq_sclk #(
  parameter int HALF_W     = 8,
  parameter int FRAME_BITS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              sclk,
  output logic              cap,
  output logic              last
);
  localparam int FC_W = $clog2(FRAME_BITS + 1);

  logic [HALF_W-1:0] hc;
  logic [HALF_W-1:0] reload;
  logic [FC_W-1:0]   nfall;
  logic              expire;

  assign reload = (half == '0) ? '0 : half - 1'b1;
  assign expire = run && (hc == '0);
  // capture in the last cycle of a high phase, just before the falling edge
  assign cap    = expire && sclk;
  assign last   = expire && !sclk && (nfall == FC_W'(FRAME_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk  <= 1'b1;
      hc    <= '0;
      nfall <= '0;
    end else if (!run) begin
      sclk  <= 1'b1;
      hc    <= reload;
      nfall <= '0;
    end else if (hc == '0) begin
      hc   <= reload;
      sclk <= ~sclk;
      if (sclk) nfall <= nfall + 1'b1;
    end else begin
      hc <= hc - 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_frame.sv
// Frame shift register, pad check and result register.
module adc_seq_frame #(
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap,
  input  logic                 last,
  input  logic                 sdata,
  output logic [DATA_BITS-1:0] data,
  output logic                 valid,
  output logic                 pad_err
);
  logic [FRAME_BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      data    <= '0;
      valid   <= 1'b0;
      pad_err <= 1'b0;
    end else begin
      valid <= last;
      if (cap) sh <= {sh[FRAME_BITS-2:0], sdata};
      if (last) begin
        data    <= sh[DATA_BITS-1:0];
        pad_err <= |sh[FRAME_BITS-1:DATA_BITS];
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int ACQ_W      = 16,
  parameter int HALF_W     = 8,
  parameter int PER_W      = 24,
  parameter int DROP_W     = 16,
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [ACQ_W-1:0]     cfg_acq_cyc,
  input  logic [HALF_W-1:0]    cfg_half_cyc,
  input  logic [PER_W-1:0]     cfg_period_cyc,
  input  logic                 adc_sdata_i,
  output logic                 adc_cs_n_o,
  output logic                 adc_sclk_o,
  output logic [DATA_BITS-1:0] res_data_o,
  output logic                 res_valid_o,
  output logic                 res_pad_err_o,
  output logic                 busy_o,
  output logic [DROP_W-1:0]    drop_cnt_o
);
  import adc_seq_pkg::*;

  seq_state_t       state;
  logic [ACQ_W-1:0] acq_cnt;
  logic             tick;
  logic             trig;
  logic             cap;
  logic             last;

  assign trig   = start_i | tick;
  assign busy_o = (state != ST_IDLE);

  adc_seq_rate #(.PER_W(PER_W)) u_rate (
    .clk(clk), .rst(rst), .period(cfg_period_cyc), .tick(tick)
  );

  adc_seq_sclk #(.HALF_W(HALF_W), .FRAME_BITS(FRAME_BITS)) u_sclk (
    .clk(clk), .rst(rst), .run(state == ST_CONV), .half(cfg_half_cyc),
    .sclk(adc_sclk_o), .cap(cap), .last(last)
  );

  adc_seq_frame #(.FRAME_BITS(FRAME_BITS), .DATA_BITS(DATA_BITS)) u_frame (
    .clk(clk), .rst(rst), .cap(cap), .last(last), .sdata(adc_sdata_i),
    .data(res_data_o), .valid(res_valid_o), .pad_err(res_pad_err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      acq_cnt    <= '0;
      adc_cs_n_o <= 1'b1;
      drop_cnt_o <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          adc_cs_n_o <= 1'b1;
          if (trig) begin
            state      <= ST_ACQ;
            adc_cs_n_o <= 1'b0;
            acq_cnt    <= (cfg_acq_cyc == '0) ? '0 : cfg_acq_cyc - 1'b1;
          end
        end
        ST_ACQ: begin
          if (trig) drop_cnt_o <= drop_cnt_o + 1'b1;
          if (acq_cnt == '0) begin
            state      <= ST_CONV;
            adc_cs_n_o <= 1'b1;   // sample instant, conversion starts
          end else begin
            acq_cnt <= acq_cnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (trig) drop_cnt_o <= drop_cnt_o + 1'b1;
          if (last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              sclk,
  input logic              valid,
  input logic [DROP_W-1:0] drop
);
  AST_ACQ_SCLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> sclk); // R2
  AST_FALL_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> cs_n); // R4
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R5
  AST_VALID_LINK_IDLE: assert property (@(posedge clk) disable iff (rst)
    valid |-> (cs_n && sclk)); // R9
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(drop) |-> drop == DROP_W'($past(drop) + 1'b1)); // R7
  AST_CS_FALL_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(sclk)); // R9
endmodule

bind adc_seq_ctrl adc_seq_chk #(.DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(adc_cs_n_o), .sclk(adc_sclk_o),
  .valid(res_valid_o), .drop(drop_cnt_o)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] acq = 16'd4;
  logic [7:0]  half = 8'd2;
  logic [23:0] period = '0;
  logic        sd = 1'b1;
  logic        cs_n, sclk, valid, pad_err, busy;
  logic [11:0] data;
  logic [15:0] drop;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst(rst), .start_i(start), .cfg_acq_cyc(acq),
    .cfg_half_cyc(half), .cfg_period_cyc(period), .adc_sdata_i(sd),
    .adc_cs_n_o(cs_n), .adc_sclk_o(sclk), .res_data_o(data),
    .res_valid_o(valid), .res_pad_err_o(pad_err), .busy_o(busy),
    .drop_cnt_o(drop)
  );

  // converter model: first bit out at chip-select rise, next on each fall
  logic [15:0] dev_word = '0;
  logic [15:0] dev_sh;
  int dev_falls = 0;
  always @(posedge cs_n) begin
    dev_sh = dev_word; dev_falls = 0; sd <= #1 dev_sh[15];
  end
  always @(negedge sclk) if (cs_n) begin
    dev_falls++;
    if (dev_falls < 16) begin dev_sh = dev_sh << 1; sd <= #1 dev_sh[15]; end
    else sd <= #1 1'b1;
  end

  // link monitor
  int exp_h = 1, cyc = 0, low_len = 0, last_low = 0, runlen = 0;
  int nfalls = 0, phase_bad = 0, cs_falls = 0, fall_cyc = 0, prev_fall_cyc = 0;
  bit in_frame = 0, prev_cs = 1, prev_sclk = 1;
  always @(negedge clk) if (!rst) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      cs_falls++; prev_fall_cyc = fall_cyc; fall_cyc = cyc; low_len = 0;
    end
    if (!cs_n) low_len++;
    if (!prev_cs && cs_n) begin
      in_frame = 1; last_low = low_len; runlen = 1; nfalls = 0;
    end else if (in_frame && cs_n) begin
      if (sclk != prev_sclk) begin
        if (runlen != exp_h) phase_bad++;
        runlen = 1;
        if (!sclk) nfalls++;
      end else runlen++;
    end
    if (valid) in_frame = 0;
    prev_cs = cs_n; prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_valid(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (valid) begin ok = 1; break; end
    end
    #1;
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic do_frame(input logic [11:0] val, input logic [3:0] pad,
                          input int p, input int h);
    bit ok;
    @(negedge clk);
    acq = 16'(p); half = 8'(h); exp_h = eff(h);
    dev_word = {pad, val}; phase_bad = 0;
    pulse_start();
    wait_valid(ok);
    chk(ok, "R5 valid seen", ok, 1);
    chk(data == val, "R5 result", data, val);
    chk(pad_err == (pad != 0), "R6 pad flag", pad_err, pad != 0);
    chk(last_low == eff(p), "R2 cs low length", last_low, eff(p));
    chk(nfalls == 16, "R4 falling edges", nfalls, 16);
    chk(phase_bad == 0, "R3 phase lengths", phase_bad, 0);
    @(negedge clk);
    chk(!valid, "R5 strobe one cycle", valid, 0);
    repeat (3) @(negedge clk);
    chk(cs_n && sclk, "R9 link idle", {cs_n, sclk}, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    int d0, f0, c0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n && sclk, "R1 link lines high", {cs_n, sclk}, 3);
    chk(!valid && drop == 0 && data == 0, "R1 result regs", {valid, drop}, 0);

    // directed corners
    do_frame(12'h000, 4'h0, 1, 1);
    do_frame(12'hFFF, 4'h0, 0, 0);   // zero config values act as 1
    do_frame(12'h800, 4'h8, 7, 3);
    do_frame(12'h001, 4'h0, 12, 2);
    do_frame(12'hA5A, 4'h1, 3, 5);

    // constrained random
    for (int n = 0; n < 20; n++) begin
      logic [3:0] pd;
      pd = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'h0;
      do_frame(12'($urandom), pd, 1 + int'($urandom % 40), 1 + int'($urandom % 5));
    end

    // R7: triggers during acquire and convert are dropped
    @(negedge clk);
    acq = 16'd40; half = 8'd4; exp_h = 4; dev_word = 16'h0123;
    d0 = int'(drop); f0 = cs_falls;
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_start();
    repeat (60) @(negedge clk);
    pulse_start();
    wait_valid(ok);
    chk(data == 12'h123, "R7 result intact", data, 12'h123);
    chk(int'(drop) == d0 + 2, "R7 drop count", drop, d0 + 2);
    chk(cs_falls == f0 + 1, "R7 no extra frame", cs_falls - f0, 1);

    // R8: periodic triggering
    repeat (5) @(negedge clk);
    acq = 16'd20; half = 8'd3; exp_h = 3; dev_word = 16'h0456;
    period = 24'd600;
    wait (cs_falls >= f0 + 3);
    @(negedge clk);
    c0 = cs_falls;
    wait (cs_falls >= c0 + 2);
    #1;
    chk(fall_cyc - prev_fall_cyc == 600, "R8 frame spacing", fall_cyc - prev_fall_cyc, 600);
    wait_valid(ok);
    chk(data == 12'h456, "R8 periodic result", data, 12'h456);
    period = '0;
    c0 = cs_falls;
    repeat (2000) @(negedge clk);
    chk(cs_falls == c0, "R8 timer disabled", cs_falls - c0, 0);
    chk(cs_n && sclk, "R9 idle after timer off", {cs_n, sclk}, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule